// File: doc/BRIEF.md
# Two-Lane Keyed Write Gate for a Clock Control Register

This block holds a 16-bit clock control register and lets a byte-wide bus change it only when a deliberate key sequence comes first. The register is split into a low lane and a high lane. Each lane has its own two-value key. Software writes the first key and then the second key to that lane's address on back-to-back bus cycles. The lane then accepts one data write, and only in the single cycle straight after the second key.

A write that arrives without that unlock is dropped. It gives no error and no response. Three bit positions are status fields driven by hardware and never by the bus: a two-bit current-source code at bits 13:12 and a clock-fail flag at bit 3. The register output always shows their live input values.

Each lane runs its own unlock state machine. Any cycle that is not a write to a lane, including an idle cycle or a write to the other lane, cancels that lane's sequence. The asynchronous reset is released synchronously inside the block, so the block stays in reset for two clock edges after `rst_n` rises.

Top module: `keyed_reg_gate`

## Requirements
- R1: While reset is held and after it is released, every writable bit of `reg_q` reads 0. Bits 13:12 show `src_st` and bit 3 shows `fail_in`. Both lanes start locked.
- R2: Writes of 0x46 and then 0x57 to the low lane (address 0) on consecutive cycles, followed by a write of V to address 0 in the next cycle, set `reg_q[7:0]` to V with bit 3 masked (writable mask 0xF7).
- R3: Writes of 0x78 and then 0x9A to the high lane (address 1) on consecutive cycles, followed by a write of V to address 1 in the next cycle, set `reg_q[15:8]` to V with bits 5:4 of the byte masked (writable mask 0xCF).
- R4: The write window lasts one cycle only. A write two or more cycles after the second key is dropped, and so is a second write directly after a successful one.
- R5: A write to either lane without a preceding unlock leaves `reg_q` unchanged.
- R6: An idle cycle or a write to the other lane between the two keys cancels the sequence, and the write that follows is dropped.
- R7: If the first write is not the first key, or the second write is not the second key, the following write is dropped.
- R8: A repeated first key restarts the sequence, so first key, first key, second key, data opens the lane.
- R9: `reg_q[13:12]` always equals `src_st` and `reg_q[3]` always equals `fail_in`, even after an unlocked write of any value.
- R10: The lanes unlock independently. A completed high-lane key sequence does not let a low-lane write through in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_addr | input | ADDR_W (1) | Byte lane address: 0 is the low lane, 1 is the high lane |
| bus_wdata | input | 8 | Write data byte |
| src_st | input | 2 | Current clock-source status, shown at bits 13:12 |
| fail_in | input | 1 | Clock-fail status flag, shown at bit 3 |
| reg_q | output | 16 | Register contents with the status fields overlaid |

## Verification
The assertions assume that the bus carries at most one write per cycle, so that two lanes can never see their second key in the same cycle. They also assume that the bus inputs change only away from the active clock edge. The stimulus meets both conditions by driving a single address on the falling edge through one task. After each key group it inserts an idle cycle, so a data byte that happens to equal a key value cannot start the next group's sequence by accident. The status inputs change only on those falling edges.

// File: rtl/kg_pkg.sv
package kg_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_t;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned REG_W  = 16;
endpackage

// File: rtl/kg_rst_sync.sv
module kg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/kg_lane_fsm.sv
module kg_lane_fsm
  import kg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 1,
  parameter logic [ADDR_W-1:0] LANE_ADDR = '0,
  parameter logic [7:0]  KEY1      = 8'h00,
  parameter logic [7:0]  KEY2      = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              win_open,
  output logic              lane_hit
);
  lk_state_t state_q, state_d;
  logic      is_k1, is_k2;

  assign lane_hit = we && (addr == LANE_ADDR);
  assign is_k1    = lane_hit && (wdata == KEY1);
  assign is_k2    = lane_hit && (wdata == KEY2);

  always_comb begin
    state_d = LK_IDLE;
    case (state_q)
      LK_IDLE: state_d = is_k1 ? LK_HALF : LK_IDLE;
      LK_HALF: begin
        if (is_k2)      state_d = LK_OPEN;
        else if (is_k1) state_d = LK_HALF;
        else            state_d = LK_IDLE;
      end
      LK_OPEN: state_d = LK_IDLE;
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_IDLE;
    else        state_q <= state_d;
  end

  assign win_open = (state_q == LK_OPEN);

  // R2 R3
  key_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> $past(state_q == LK_HALF && lane_hit && wdata == KEY2));

  // R4
  open_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |=> !win_open);
endmodule

// File: rtl/kg_byte_store.sv
module kg_byte_store #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] WMASK   = '1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ok,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_ok) q_d = (q & ~WMASK) | (d & WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_ok) q <= q_d;
  end

  // R5
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |=> $stable(q));
endmodule

// File: rtl/keyed_reg_gate.sv
module keyed_reg_gate
  import kg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 1,
  parameter logic [ADDR_W-1:0] LO_ADDR = 1'b0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 1'b1,
  parameter logic [7:0]  LO_KEY1 = 8'h46,
  parameter logic [7:0]  LO_KEY2 = 8'h57,
  parameter logic [7:0]  HI_KEY1 = 8'h78,
  parameter logic [7:0]  HI_KEY2 = 8'h9A,
  parameter int unsigned SRC_LSB = 12,
  parameter int unsigned FAIL_BIT = 3,
  parameter logic [15:0] RST_VAL = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [1:0]        src_st,
  input  logic              fail_in,
  output logic [15:0]       reg_q
);
  localparam logic [15:0] RO_MASK  = (16'h3 << SRC_LSB) | (16'h1 << FAIL_BIT);
  localparam logic [15:0] W_MASK   = ~RO_MASK;
  localparam logic [7:0]  LO_WMASK = W_MASK[7:0];
  localparam logic [7:0]  HI_WMASK = W_MASK[15:8];

  logic       rst_s_n;
  logic [1:0] lane_open, lane_hit;
  logic [7:0] lo_q, hi_q;
  logic [15:0] status_v;

  kg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  localparam logic [1:0][ADDR_W-1:0] L_ADDR = {HI_ADDR, LO_ADDR};
  localparam logic [1:0][7:0]        L_K1   = {HI_KEY1, LO_KEY1};
  localparam logic [1:0][7:0]        L_K2   = {HI_KEY2, LO_KEY2};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    kg_lane_fsm #(
      .ADDR_W(ADDR_W), .LANE_ADDR(L_ADDR[g]), .KEY1(L_K1[g]), .KEY2(L_K2[g])
    ) u_fsm (
      .clk(clk), .rst_n(rst_s_n), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .win_open(lane_open[g]), .lane_hit(lane_hit[g])
    );
  end

  kg_byte_store #(.W(8), .WMASK(LO_WMASK), .RST_VAL(RST_VAL[7:0] & LO_WMASK)) u_lo (
    .clk(clk), .rst_n(rst_s_n), .wr_ok(lane_open[0] && lane_hit[0]),
    .d(bus_wdata), .q(lo_q)
  );

  kg_byte_store #(.W(8), .WMASK(HI_WMASK), .RST_VAL(RST_VAL[15:8] & HI_WMASK)) u_hi (
    .clk(clk), .rst_n(rst_s_n), .wr_ok(lane_open[1] && lane_hit[1]),
    .d(bus_wdata), .q(hi_q)
  );

  always_comb begin
    status_v = '0;
    status_v[SRC_LSB +: 2] = src_st;
    status_v[FAIL_BIT]     = fail_in;
  end

  assign reg_q = ({hi_q, lo_q} & W_MASK) | status_v;

  // R10
  lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(lane_open));
endmodule

// File: tb/sim_keyed_reg_gate.sv
module sim_keyed_reg_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LK1 = 8'h46, LK2 = 8'h57, HK1 = 8'h78, HK2 = 8'h9A;

  logic clk = 1'b0;
  logic rst_n;
  logic we;
  logic [0:0] addr;
  logic [7:0] wdata;
  logic [1:0] src;
  logic fail;
  logic [15:0] q;

  int total = 0, bad = 0;
  logic [7:0] exp_lo = 8'h00, exp_hi = 8'h00;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_reg_gate u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .src_st(src), .fail_in(fail), .reg_q(q)
  );

  function automatic logic [15:0] expv();
    return ({exp_hi, exp_lo} & 16'hCFF7) | {2'b00, src, 12'h000} | {12'h000, fail, 3'b000};
  endfunction

  task automatic cyc(input logic w, input logic a, input logic [7:0] d);
    @(negedge clk);
    we = w; addr = a; wdata = d;
  endtask

  task automatic chk(input string req);
    total++;
    if (q !== expv()) begin
      bad++;
      $display("FAIL %s: reg_q=%h expected=%h", req, q, expv());
    end
  endtask

  task automatic idle_chk(input string req);
    cyc(0, 0, 8'h00);
    chk(req);
  endtask

  initial begin
    int cycles = 0;
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected<=200000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; we = 0; addr = 0; wdata = 0; src = 2'b10; fail = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release");

    // R5: locked writes to both lanes
    cyc(1, 0, 8'hFF); cyc(1, 1, 8'hFF); idle_chk("R5 locked");

    // R2 + R9: exhaustive low-lane data sweep
    for (int v = 0; v < 256; v++) begin
      cyc(1, 0, LK1); cyc(1, 0, LK2); cyc(1, 0, v[7:0]);
      src = v[1:0]; fail = v[2];
      exp_lo = v[7:0] & 8'hF7;
      idle_chk("R2 R9 low sweep");
    end

    // R3 + R9: exhaustive high-lane data sweep
    for (int v = 0; v < 256; v++) begin
      cyc(1, 1, HK1); cyc(1, 1, HK2); cyc(1, 1, v[7:0]);
      src = v[4:3]; fail = v[0];
      exp_hi = v[7:0] & 8'hCF;
      idle_chk("R3 R9 high sweep");
    end

    // R9: unlocked all-ones write cannot touch status bits
    src = 2'b00; fail = 1'b0;
    cyc(1, 0, LK1); cyc(1, 0, LK2); cyc(1, 0, 8'hFF); exp_lo = 8'hF7;
    cyc(1, 1, HK1); cyc(1, 1, HK2); cyc(1, 1, 8'hFF); exp_hi = 8'hCF;
    idle_chk("R9 status kept");

    // R7: sweep first key value
    for (int d = 0; d < 256; d++) begin
      cyc(1, 0, d[7:0]); cyc(1, 0, LK2); cyc(1, 0, 8'h3C);
      if (d[7:0] == LK1) exp_lo = 8'h3C & 8'hF7;
      idle_chk("R7 first key sweep");
      cyc(1, 0, LK1); cyc(1, 0, LK2); cyc(1, 0, 8'h00); exp_lo = 8'h00;
      idle_chk("R2 restore");
    end

    // R7 + R8: sweep second key value
    for (int d = 0; d < 256; d++) begin
      cyc(1, 1, HK1); cyc(1, 1, d[7:0]); cyc(1, 1, 8'h3C);
      if (d[7:0] == HK2) exp_hi = 8'h3C & 8'hCF;
      idle_chk("R7 second key sweep");
      cyc(1, 1, HK1); cyc(1, 1, HK2); cyc(1, 1, 8'h00); exp_hi = 8'h00;
      idle_chk("R3 restore");
    end

    // R4: late write dropped
    cyc(1, 0, LK1); cyc(1, 0, LK2); cyc(0, 0, 8'h00); cyc(1, 0, 8'hA5);
    idle_chk("R4 late write");
    // R4: second back-to-back write dropped
    cyc(1, 1, HK1); cyc(1, 1, HK2); cyc(1, 1, 8'h81); cyc(1, 1, 8'h42);
    exp_hi = 8'h81 & 8'hCF;
    idle_chk("R4 second write");

    // R6: idle between keys
    cyc(1, 0, LK1); cyc(0, 0, 8'h00); cyc(1, 0, LK2); cyc(1, 0, 8'h66);
    idle_chk("R6 idle gap");
    // R6: other-lane write between keys
    cyc(1, 0, LK1); cyc(1, 1, 8'h00); cyc(1, 0, LK2); cyc(1, 0, 8'h66);
    idle_chk("R6 other lane gap");

    // R8: repeated first key restarts
    cyc(1, 0, LK1); cyc(1, 0, LK1); cyc(1, 0, LK2); cyc(1, 0, 8'hC4);
    exp_lo = 8'hC4 & 8'hF7;
    idle_chk("R8 restart");

    // R10: high unlock does not open low lane, and high window expires
    cyc(1, 1, HK1); cyc(1, 1, HK2); cyc(1, 0, 8'h11); cyc(1, 1, 8'h22);
    idle_chk("R10 lane independence");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule